// File: doc/BRIEF.md
# Ring-Buffer UART DMA Channel

This block is one channel of a byte-wide DMA engine that carries traffic between system memory and a UART. The memory region works as a ring (a virtual FIFO) described by a base address, a length and two pointers. Each pointer carries a wrap bit above its index. In the transmit direction software advances the write pointer and the channel fetches bytes from memory, passing them to the UART. In the receive direction the channel stores UART bytes into memory and software advances the read pointer.

Software controls the channel through a 32-bit register port with a byte offset. The block holds the enable, stop, flush, warm-reset, interrupt and geometry registers and runs the stop and flush handshakes. It drives one level interrupt. Memory traffic leaves through a single-byte request/grant port. The direction is a static strap, changed only while the channel is disabled.

Top module: `vff_dma_chan`

## Requirements
- R1: After reset every register reads 0, debug status reads 0 (idle), `irq_o` is 0 and no memory request is raised.
- R2: Software writes and reads back the following registers: base address at 0x1C (32 bits), length at 0x24 (16 bits) and threshold at 0x28 (16 bits). Bit 0 of the enable register at 0x08 reads back exactly 1 after software writes 1.
- R3: Pointers are 17 bits wide: bits [15:0] hold the index and bit 16 is the wrap flag. In transmit, the channel reads memory at base plus the read-pointer index (0x30) and hands the bytes to the UART in order. When an index reaches the length, it returns to 0 and the wrap flag inverts. A memory request holds its address, direction and data until it is granted. Software writes to the read pointer are ignored in transmit.
- R4: Valid size (0x3C) is the write index minus the read index, plus the length when the two wrap flags differ. Left size (0x40) is the length minus the valid size.
- R5: In transmit, a fetch starts only when the valid size is nonzero and either reaches the threshold or a flush is pending. Below the threshold, data stays in the ring.
- R6: Writing 1 to bit 0 of flush (0x14) sets it. Flush reads 1 until pending data is gone: in transmit, the ring is empty and the UART has taken the last byte; in receive, no memory write is outstanding. Flush then clears by itself. In receive, completing a flush sets interrupt flag bit 1.
- R7: Writing 1 to bit 0 of stop (0x10) makes hardware clear enable once no memory request is outstanding. While a request waits for its grant, enable stays 1. Writing 0 to stop completes the sequence.
- R8: Writing 1 to bit 0 of the warm-reset register (0x0C) clears enable, stop, flush, the flags and both pointers as soon as no memory request is outstanding. That register always reads 0.
- R9: Writing 0 to enable pauses the channel: no new memory access starts.
- R10: In transmit, flag bit 0 (0x00) sets while enabled with a nonzero threshold and the left size is at least the threshold. Any write with bit 0 equal to 0 clears it. Interrupt enable (0x04) keeps only bit 0.
- R11: In receive, UART bytes are written to base plus the write-pointer index (0x2C), and hardware advances the write pointer. `rx_ready_o` stays low while the left size is 0. Software writes to the write pointer are ignored in receive.
- R12: In receive, flag bit 0 sets while enabled with a nonzero threshold and the valid size is at least the threshold. Flag bits stay set until cleared by writing 1 to bits [1:0] of 0x00; writing 0 has no effect.
- R13: `irq_o` is the OR of flag bits whose interrupt-enable bit is set. Writing 0 to 0x04 masks it without clearing the flags.
- R14: Debug status (0x50) reads 3 (stopping) when enabled with stop or warm reset pending. Otherwise it reads 2 (flushing) while flush is set, 1 (active) when enabled, and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rx_i | input | 1 | Direction strap: 1 receive, 0 transmit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory byte request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant, completes the request |
| mem_rdata_i | input | 8 | Read data, valid with grant |
| tx_valid_o | output | 1 | Byte available for the UART |
| tx_data_o | output | 8 | Byte to the UART |
| tx_ready_i | input | 1 | UART accepts the byte |
| rx_valid_i | input | 1 | UART offers a byte |
| rx_data_i | input | 8 | Byte from the UART |
| rx_ready_o | output | 1 | Channel accepts the byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a stop that arrives while a memory request is waiting for its grant. Enable must stay set and debug status must read stopping until the grant lands. The bench's memory model can withhold grants. It holds one back, enables the channel with data above the threshold, writes stop, checks the in-flight state, and then releases the grant. Pointer wrap in both directions is reached by writing a wrapped write pointer in transmit and by filling the receive ring until it is full.

// File: rtl/vff_pkg.sv
package vff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_FLUSH  = 2'd2,
    ST_STOP   = 2'd3
  } vff_state_e;

  localparam logic [7:0] OFF_IFLAG = 8'h00;
  localparam logic [7:0] OFF_IEN   = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h08;
  localparam logic [7:0] OFF_RST   = 8'h0C;
  localparam logic [7:0] OFF_STOP  = 8'h10;
  localparam logic [7:0] OFF_FLUSH = 8'h14;
  localparam logic [7:0] OFF_BASE  = 8'h1C;
  localparam logic [7:0] OFF_LEN   = 8'h24;
  localparam logic [7:0] OFF_THRE  = 8'h28;
  localparam logic [7:0] OFF_WPT   = 8'h2C;
  localparam logic [7:0] OFF_RPT   = 8'h30;
  localparam logic [7:0] OFF_VALID = 8'h3C;
  localparam logic [7:0] OFF_LEFT  = 8'h40;
  localparam logic [7:0] OFF_DBG   = 8'h50;
endpackage

// File: rtl/vff_ptr_next.sv
module vff_ptr_next #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W:0]   ptr_i,
  input  logic [PTR_W-1:0] len_i,
  output logic [PTR_W:0]   nxt_o
);
  logic [PTR_W:0] inc;

  always_comb begin
    inc = {1'b0, ptr_i[PTR_W-1:0]} + 1'b1;
    if (inc == {1'b0, len_i}) nxt_o = {~ptr_i[PTR_W], {PTR_W{1'b0}}};
    else                      nxt_o = {ptr_i[PTR_W], inc[PTR_W-1:0]};
  end
endmodule

// File: rtl/vff_level.sv
module vff_level #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W:0]   wpt_i,
  input  logic [PTR_W:0]   rpt_i,
  input  logic [PTR_W-1:0] len_i,
  output logic [PTR_W:0]   valid_o,
  output logic [PTR_W:0]   left_o
);
  logic [PTR_W:0] diff;

  always_comb begin
    diff = {1'b0, wpt_i[PTR_W-1:0]} - {1'b0, rpt_i[PTR_W-1:0]};
    if (wpt_i[PTR_W] != rpt_i[PTR_W]) diff = diff + {1'b0, len_i};
    valid_o = diff;
    left_o  = {1'b0, len_i} - diff;
  end
endmodule

// File: rtl/vff_mover.sv
module vff_mover #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic              run_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [PTR_W-1:0]  ridx_i,
  input  logic [PTR_W-1:0]  widx_i,
  input  logic [PTR_W:0]    valid_i,
  input  logic [PTR_W:0]    left_i,
  input  logic [PTR_W-1:0]  thre_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              adv_o,
  output logic              busy_o,
  output logic              drained_o
);
  localparam int PAD_W = ADDR_W - PTR_W;

  logic              busy_q, we_q, stage_full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q, stage_q;
  logic              tx_start, rx_take, at_thre;

  assign at_thre    = valid_i >= {1'b0, thre_i};
  assign tx_start   = !dir_rx_i && run_i && !busy_q && !stage_full_q &&
                      (valid_i != '0) && (at_thre || flush_i);
  assign rx_ready_o = dir_rx_i && run_i && !busy_q && (left_i != '0);
  assign rx_take    = rx_valid_i && rx_ready_o;
  assign adv_o      = busy_q && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      we_q         <= 1'b0;
      addr_q       <= '0;
      data_q       <= '0;
      stage_q      <= '0;
      stage_full_q <= 1'b0;
    end else begin
      if (tx_start) begin
        busy_q <= 1'b1;
        we_q   <= 1'b0;
        addr_q <= base_i + {{PAD_W{1'b0}}, ridx_i};
      end else if (rx_take) begin
        busy_q <= 1'b1;
        we_q   <= 1'b1;
        addr_q <= base_i + {{PAD_W{1'b0}}, widx_i};
        data_q <= rx_data_i;
      end else if (adv_o) begin
        busy_q <= 1'b0;
      end
      if (adv_o && !we_q) begin
        stage_q      <= mem_rdata_i;
        stage_full_q <= 1'b1;
      end else if (stage_full_q && tx_ready_i) begin
        stage_full_q <= 1'b0;
      end
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign tx_valid_o  = stage_full_q;
  assign tx_data_o   = stage_q;
  assign busy_o      = busy_q;
  assign drained_o   = dir_rx_i ? !busy_q : (!busy_q && !stage_full_q && valid_i == '0);

  a_r3_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r3_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

// File: rtl/vff_regs.sv
module vff_regs
  import vff_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [PTR_W:0]    valid_i,
  input  logic [PTR_W:0]    left_i,
  input  logic [PTR_W:0]    hw_nxt_i,
  input  logic              adv_i,
  input  logic              busy_i,
  input  logic              drained_i,
  output logic              run_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  len_o,
  output logic [PTR_W-1:0]  thre_o,
  output logic [PTR_W:0]    wpt_o,
  output logic [PTR_W:0]    rpt_o,
  output logic              irq_o
);
  localparam int PZ = 32 - PTR_W - 1;
  localparam int LZ = 32 - PTR_W;

  logic              en_q, stop_q, rst_pend_q, flush_q;
  logic [1:0]        flag_q, ien_q, flag_set, flag_clr, ien_mask;
  logic [ADDR_W-1:0] base_q;
  logic [PTR_W-1:0]  len_q, thre_q;
  logic [PTR_W:0]    wpt_q, rpt_q;
  logic              halt, quiesce, flush_done, thre_ok;
  vff_state_e        state;

  function automatic logic hit(input logic [7:0] off);
    return reg_wr_i && (reg_addr_i == off[REG_AW-1:0]);
  endfunction

  assign halt       = stop_q | rst_pend_q;
  assign quiesce    = halt && !busy_i;
  assign flush_done = flush_q && drained_i;
  assign thre_ok    = en_q && (thre_q != '0);
  assign ien_mask   = dir_rx_i ? 2'b11 : 2'b01;

  always_comb begin
    flag_set = 2'b00;
    flag_clr = 2'b00;
    if (dir_rx_i) begin
      flag_set[0] = thre_ok && (valid_i >= {1'b0, thre_q});
      flag_set[1] = flush_done;
      if (hit(OFF_IFLAG)) flag_clr = reg_wdata_i[1:0];
    end else begin
      flag_set[0] = thre_ok && (left_i >= {1'b0, thre_q});
      if (hit(OFF_IFLAG) && !reg_wdata_i[0]) flag_clr = 2'b01;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; stop_q <= 1'b0; rst_pend_q <= 1'b0; flush_q <= 1'b0;
      flag_q <= '0; ien_q <= '0; base_q <= '0; len_q <= '0; thre_q <= '0;
      wpt_q <= '0; rpt_q <= '0;
    end else if (rst_pend_q && !busy_i) begin
      en_q <= 1'b0; stop_q <= 1'b0; rst_pend_q <= 1'b0; flush_q <= 1'b0;
      flag_q <= '0; wpt_q <= '0; rpt_q <= '0;
    end else begin
      if (quiesce)          en_q <= 1'b0;
      else if (hit(OFF_EN)) en_q <= reg_wdata_i[0] & ~halt;
      if (hit(OFF_STOP))  stop_q <= reg_wdata_i[0];
      if (hit(OFF_RST) && reg_wdata_i[0]) rst_pend_q <= 1'b1;
      if (hit(OFF_FLUSH) && reg_wdata_i[0]) flush_q <= 1'b1;
      else if (flush_done)                  flush_q <= 1'b0;
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      if (hit(OFF_IEN))  ien_q  <= reg_wdata_i[1:0] & ien_mask;
      if (hit(OFF_BASE)) base_q <= reg_wdata_i[ADDR_W-1:0];
      if (hit(OFF_LEN))  len_q  <= reg_wdata_i[PTR_W-1:0];
      if (hit(OFF_THRE)) thre_q <= reg_wdata_i[PTR_W-1:0];
      if (dir_rx_i) begin
        if (adv_i)            wpt_q <= hw_nxt_i;
        if (hit(OFF_RPT))     rpt_q <= reg_wdata_i[PTR_W:0];
      end else begin
        if (adv_i)            rpt_q <= hw_nxt_i;
        if (hit(OFF_WPT))     wpt_q <= reg_wdata_i[PTR_W:0];
      end
    end
  end

  always_comb begin
    if (en_q && halt) state = ST_STOP;
    else if (flush_q) state = ST_FLUSH;
    else if (en_q)    state = ST_ACTIVE;
    else              state = ST_IDLE;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_IFLAG[REG_AW-1:0]: reg_rdata_o = {30'b0, flag_q};
      OFF_IEN[REG_AW-1:0]:   reg_rdata_o = {30'b0, ien_q};
      OFF_EN[REG_AW-1:0]:    reg_rdata_o = {31'b0, en_q};
      OFF_STOP[REG_AW-1:0]:  reg_rdata_o = {31'b0, stop_q};
      OFF_FLUSH[REG_AW-1:0]: reg_rdata_o = {31'b0, flush_q};
      OFF_BASE[REG_AW-1:0]:  reg_rdata_o = base_q;
      OFF_LEN[REG_AW-1:0]:   reg_rdata_o = {{LZ{1'b0}}, len_q};
      OFF_THRE[REG_AW-1:0]:  reg_rdata_o = {{LZ{1'b0}}, thre_q};
      OFF_WPT[REG_AW-1:0]:   reg_rdata_o = {{PZ{1'b0}}, wpt_q};
      OFF_RPT[REG_AW-1:0]:   reg_rdata_o = {{PZ{1'b0}}, rpt_q};
      OFF_VALID[REG_AW-1:0]: reg_rdata_o = {{PZ{1'b0}}, valid_i};
      OFF_LEFT[REG_AW-1:0]:  reg_rdata_o = {{PZ{1'b0}}, left_i};
      OFF_DBG[REG_AW-1:0]:   reg_rdata_o = {30'b0, state};
      default:               reg_rdata_o = '0;
    endcase
  end

  assign run_o   = en_q && !halt;
  assign flush_o = flush_q;
  assign base_o  = base_q;
  assign len_o   = len_q;
  assign thre_o  = thre_q;
  assign wpt_o   = wpt_q;
  assign rpt_o   = rpt_q;
  assign irq_o   = |(flag_q & ien_q);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  a_r7_stop_waits_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && en_q && busy_i && !hit(OFF_EN)) |=> en_q);

  a_r6_flush_holds_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && busy_i) |=> flush_q);

  a_r8_warm_rst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pend_q && !busy_i) |=> (!en_q && !stop_q && wpt_q == '0 && rpt_q == '0));
endmodule

// File: rtl/vff_dma_chan.sv
module vff_dma_chan #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 16,
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              irq_o
);
  logic              run, flush, adv, busy, drained;
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  len, thre;
  logic [PTR_W:0]    wpt, rpt, valid, left, hw_ptr, hw_nxt;

  assign hw_ptr = dir_rx_i ? wpt : rpt;

  vff_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .REG_AW(REG_AW)) i_regs (
    .clk_i, .rst_ni, .dir_rx_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .valid_i(valid), .left_i(left), .hw_nxt_i(hw_nxt), .adv_i(adv), .busy_i(busy),
    .drained_i(drained), .run_o(run), .flush_o(flush), .base_o(base), .len_o(len),
    .thre_o(thre), .wpt_o(wpt), .rpt_o(rpt), .irq_o
  );

  vff_level #(.PTR_W(PTR_W)) i_level (
    .wpt_i(wpt), .rpt_i(rpt), .len_i(len), .valid_o(valid), .left_o(left)
  );

  vff_ptr_next #(.PTR_W(PTR_W)) i_ptr_next (
    .ptr_i(hw_ptr), .len_i(len), .nxt_o(hw_nxt)
  );

  vff_mover #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_mover (
    .clk_i, .rst_ni, .dir_rx_i, .run_i(run), .flush_i(flush), .base_i(base),
    .ridx_i(rpt[PTR_W-1:0]), .widx_i(wpt[PTR_W-1:0]), .valid_i(valid), .left_i(left),
    .thre_i(thre), .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i,
    .mem_rdata_i, .tx_valid_o, .tx_data_o, .tx_ready_i, .rx_valid_i, .rx_data_i,
    .rx_ready_o, .adv_o(adv), .busy_o(busy), .drained_o(drained)
  );
endmodule

// File: tb/test_vff_dma_chan.sv
`timescale 1ns/1ps
module test_vff_dma_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_rx_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_gnt_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b1;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ready_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic       gnt_hold = 1'b0;
  logic [7:0] mem [0:255];
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  vff_dma_chan i_vff_dma_chan (
    .clk_i(clk), .rst_ni, .dir_rx_i, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i,
    .tx_valid_o, .tx_data_o, .tx_ready_i, .rx_valid_i, .rx_data_i, .rx_ready_o, .irq_o
  );

  // memory model: one-cycle grant, can be held off
  always @(negedge clk) begin
    if (mem_req_o && !mem_gnt_i && !gnt_hold) begin
      if (mem_we_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
      else          mem_rdata_i = mem[mem_addr_o[7:0]];
      mem_gnt_i = 1'b1;
    end else begin
      mem_gnt_i = 1'b0;
    end
  end

  // scoreboard monitor for UART-side bytes
  always @(negedge clk) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected tx byte actual=%h expected=none", tx_data_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data_o !== e) begin
          errors++;
          $display("FAIL R3 tx byte order actual=%h expected=%h", tx_data_o, e);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); chk(tag, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    exp_q.push_back(b);
  endtask

  task automatic wait_flush();
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(8'h14, d);
      if (d[0] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic rx_send(input logic [7:0] b, input int lim, output logic ok);
    ok = 1'b0;
    rx_valid_i = 1'b1; rx_data_i = b;
    for (int i = 0; i < lim; i++) begin
      #1;
      if (rx_ready_o) begin
        ok = 1'b1;
        @(posedge clk); @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) mem[8'h40 + i] = 8'hA0 + 8'(i);
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    // R1 reset state
    rd_chk("R1 flag", 8'h00, 0);
    rd_chk("R1 enable", 8'h08, 0);
    rd_chk("R1 debug", 8'h50, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 mem_req", {31'b0, mem_req_o}, 0);

    // R2 geometry and enable readback (transmit)
    wr(8'h1C, 32'h0000_0040);
    wr(8'h24, 8);
    wr(8'h28, 8);
    rd_chk("R2 base", 8'h1C, 32'h40);
    rd_chk("R2 length", 8'h24, 8);
    rd_chk("R2 threshold", 8'h28, 8);
    wr(8'h2C, 5);
    wr(8'h08, 1);
    rd_chk("R2 enable readback", 8'h08, 1);
    idle(10);
    rd_chk("R5 below threshold no fetch", 8'h30, 0);
    rd_chk("R4 valid", 8'h3C, 5);
    rd_chk("R4 left", 8'h40, 3);
    rd_chk("R10 flag clear while left<thre", 8'h00, 0);
    wr(8'h04, 3);
    rd_chk("R10 tx int enable bit0 only", 8'h04, 1);

    // R6 flush drains below threshold
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    wr(8'h14, 1);
    rd_chk("R6 flush reads 1", 8'h14, 1);
    rd_chk("R14 debug flushing", 8'h50, 2);
    wait_flush();
    idle(2);
    rd_chk("R6 flush self-cleared", 8'h14, 0);
    rd_chk("R3 read pointer advanced", 8'h30, 5);
    chk("R3 all bytes out", exp_q.size(), 0);
    rd_chk("R10 flag set on left>=thre", 8'h00, 1);
    chk("R13 irq asserted", {31'b0, irq_o}, 1);
    rd_chk("R14 debug active", 8'h50, 1);
    wr(8'h04, 0);
    chk("R13 irq masked", {31'b0, irq_o}, 0);
    rd_chk("R13 flag kept while masked", 8'h00, 1);

    // R3/R4 wrap in transmit
    wr(8'h2C, 32'h0001_0002);
    rd_chk("R4 valid across wrap", 8'h3C, 5);
    rd_chk("R4 left across wrap", 8'h40, 3);
    wr(8'h00, 0);
    rd_chk("R10 write 0 clears flag", 8'h00, 0);
    push(8'hA5); push(8'hA6); push(8'hA7); push(8'hA0); push(8'hA1);
    wr(8'h14, 1);
    wait_flush();
    idle(2);
    rd_chk("R3 read pointer wrapped", 8'h30, 32'h0001_0002);
    chk("R3 wrap bytes out", exp_q.size(), 0);

    // R5 threshold-driven movement
    wr(8'h28, 2);
    push(8'hA2); push(8'hA3);
    wr(8'h2C, 32'h0001_0005);
    idle(30);
    rd_chk("R5 stops below threshold", 8'h30, 32'h0001_0004);
    rd_chk("R5 one byte left", 8'h3C, 1);
    wr(8'h30, 0);
    rd_chk("R3 sw write to read pointer ignored", 8'h30, 32'h0001_0004);

    // R9 pause
    wr(8'h08, 0);
    wr(8'h2C, 32'h0001_0007);
    idle(20);
    rd_chk("R9 paused no fetch", 8'h30, 32'h0001_0004);
    chk("R9 no request while paused", {31'b0, mem_req_o}, 0);

    // R7 stop with a request in flight
    gnt_hold = 1'b1;
    wr(8'h08, 1);
    idle(3);
    chk("R7 request outstanding", {31'b0, mem_req_o}, 1);
    chk("R3 request address", mem_addr_o, 32'h44);
    wr(8'h10, 1);
    idle(3);
    rd_chk("R7 enable held during request", 8'h08, 1);
    rd_chk("R14 debug stopping", 8'h50, 3);
    push(8'hA4);
    gnt_hold = 1'b0;
    idle(6);
    rd_chk("R7 enable cleared after grant", 8'h08, 0);
    rd_chk("R7 pointer advanced once", 8'h30, 32'h0001_0005);
    wr(8'h10, 0);
    rd_chk("R7 stop cleared", 8'h10, 0);
    rd_chk("R14 debug idle", 8'h50, 0);

    // R8 warm reset
    wr(8'h0C, 1);
    idle(2);
    rd_chk("R8 enable cleared", 8'h08, 0);
    rd_chk("R8 write pointer cleared", 8'h2C, 0);
    rd_chk("R8 read pointer cleared", 8'h30, 0);
    rd_chk("R8 flags cleared", 8'h00, 0);
    rd_chk("R8 reset reads 0", 8'h0C, 0);
    chk("R3 scoreboard empty", exp_q.size(), 0);

    // receive direction
    dir_rx_i = 1'b1;
    wr(8'h1C, 32'h0000_0080);
    wr(8'h28, 6);
    wr(8'h04, 3);
    rd_chk("R13 rx int enable both bits", 8'h04, 3);
    wr(8'h08, 1);
    for (int i = 0; i < 6; i++) rx_send(8'h10 + 8'(i), 20, ok);
    idle(5);
    rd_chk("R11 write pointer advanced", 8'h2C, 6);
    for (int i = 0; i < 6; i++)
      chk("R11 rx byte stored", {24'b0, mem[8'h80 + i]}, 32'h10 + i);
    rd_chk("R12 flag on valid>=thre", 8'h00, 1);
    chk("R13 rx irq", {31'b0, irq_o}, 1);
    wr(8'h30, 6);
    rd_chk("R4 rx valid after sw read", 8'h3C, 0);
    wr(8'h00, 0);
    rd_chk("R12 writing 0 keeps flag", 8'h00, 1);
    wr(8'h00, 1);
    rd_chk("R12 W1C clears flag", 8'h00, 0);
    chk("R13 irq drops", {31'b0, irq_o}, 0);
    wr(8'h2C, 0);
    rd_chk("R11 sw write to write pointer ignored", 8'h2C, 6);

    // fill ring across wrap
    for (int i = 0; i < 8; i++) rx_send(8'h20 + 8'(i), 20, ok);
    idle(5);
    rd_chk("R11 write pointer wrapped", 8'h2C, 32'h0001_0006);
    rd_chk("R4 rx left zero", 8'h40, 0);
    chk("R11 wrap byte idx6", {24'b0, mem[8'h86]}, 32'h20);
    chk("R11 wrap byte idx7", {24'b0, mem[8'h87]}, 32'h21);
    chk("R11 wrap byte idx0", {24'b0, mem[8'h80]}, 32'h22);
    chk("R11 wrap byte idx5", {24'b0, mem[8'h85]}, 32'h27);
    rx_send(8'h55, 10, ok);
    chk("R11 full ring refuses byte", {31'b0, ok}, 0);
    chk("R11 rx_ready low when full", {31'b0, rx_ready_o}, 0);

    // R6 receive flush sets flag bit 1
    wr(8'h00, 3);
    wr(8'h14, 1);
    idle(3);
    rd_chk("R6 rx flush done", 8'h14, 0);
    begin
      logic [31:0] d;
      rd(8'h00, d);
      chk("R6 rx flush sets flag bit1", {31'b0, d[1]}, 1);
    end

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule